// File: doc/BRIEF.md
# Multiword DMA Strobe Timing Generator

This block produces the read/write strobe that paces one word of a multiword DMA transfer to a disk drive. Each word has two phases. In the active phase the strobe is high. In the recovery phase the strobe is low. Both phases are whole clock ticks, worked out from a clock-period parameter. The tick counts are rounded up, so no phase is ever shorter than its nominal time in nanoseconds.

There are four fixed timing classes:

| Class | Active (ns) | Recovery (ns) | Cycle (ns) |
|-------|-------------|---------------|------------|
| D | 62 | 125 | 187 |
| C | 125 | 125 | 250 |
| B | 187 | 250 | 437 |
| A | 250 | 312 | 562 |

The block picks a class from a requested cycle time, which it derives from the selected transfer mode and the minimum cycle time the drive reports. It uses the fastest class whose cycle covers the request.

Software or a transfer engine sets the mode and the drive's cycle value, then pulses a start request once per word. A request that arrives while a word is still in progress is held and starts the next word as soon as recovery ends. This lets words run back to back.

Top module: `dma_strobe_gen`

## Requirements
- R1: After reset, `strobe`, `busy` and `word_done` are low.
- R2: Mode codes are 0–2 for single-word modes 0–2, 3–5 for multiword modes 0–2, and 6 for any mode above multiword 2, which is treated as multiword 2. Single-word modes and multiword mode 0 request a 480 ns cycle. Multiword modes 1 and 2 request 250 ns.
- R3: For multiword modes 1 and 2 only, a drive cycle value larger than 250 ns replaces the request. A smaller drive value has no effect, and single-word modes and multiword mode 0 ignore the drive value.
- R4: Mode code 7 means no valid mode, and the request falls back to 480 ns.
- R5: The chosen class is the fastest class whose cycle is at least the request; a request above 562 ns selects class A. `word_class` reports the class of the current or last word, encoded D=0, C=1, B=2, A=3.
- R6: For each word the strobe is high for exactly ceil(active_ns / period) consecutive cycles, starting the cycle after the start request is sampled.
- R7: The strobe stays low for exactly ceil(recovery_ns / period) cycles after the active phase. Then `word_done` is high for exactly one cycle.
- R8: `busy` is high from the first strobe cycle through the last recovery cycle. It drops in the `word_done` cycle unless another word begins there.
- R9: A start request seen during the active or recovery phase begins the next word in the `word_done` cycle, with no idle gap. Several requests during one word merge into a single pending word.
- R10: The class is latched when a word starts. A mode or drive-value change during a word does not alter that word's timing or `word_class`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one word transfer |
| mode_code | input | 3 | Transfer mode code (see R2, R4) |
| drive_cyc_ns | input | CYC_W | Drive-reported minimum cycle time in ns |
| strobe | output | 1 | DMA read/write strobe, high in the active phase |
| busy | output | 1 | Word in progress |
| word_done | output | 1 | One-cycle pulse after a word's recovery ends |
| word_class | output | 2 | Timing class of the current or last word |

## Verification
The hardest behaviour to reach from the ports is a held request that lands mid-recovery. The next word must follow with no idle cycle, and several requests must collapse into one word. The stimulus counts negative edges from a known start and raises `start` twice inside the recovery window of a class-C word. It then checks that `busy` never drops, that the second strobe rises in the `word_done` cycle, and that only one extra word follows.

Class latching is reached by switching the mode from a fast class to a slow one a few cycles into the active phase. The bench then checks that the active length still matches the fast class.

The class boundaries are probed with drive values of 437 ns and 438 ns.

// File: rtl/dma_strobe_pkg.sv
package dma_strobe_pkg;

    typedef enum logic [1:0] {
        CLS_D = 2'd0,
        CLS_C = 2'd1,
        CLS_B = 2'd2,
        CLS_A = 2'd3
    } strobe_class_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_RECOV  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       valid;
        logic       multiword;
        logic [1:0] level;
    } mode_dec_t;

    localparam int NUM_CLS     = 4;
    localparam int CYC_SLOW_NS = 480;
    localparam int CYC_FAST_NS = 250;
    localparam int MAX_PHASE_NS = 312;

    function automatic int cls_active_ns(int idx);
        case (idx)
            0:       return 62;
            1:       return 125;
            2:       return 187;
            default: return 250;
        endcase
    endfunction

    function automatic int cls_recov_ns(int idx);
        case (idx)
            0:       return 125;
            1:       return 125;
            2:       return 250;
            default: return 312;
        endcase
    endfunction

    function automatic int cls_cycle_ns(int idx);
        return cls_active_ns(idx) + cls_recov_ns(idx);
    endfunction

    function automatic int ns_to_ticks(int ns, int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic mode_dec_t decode_mode(logic [2:0] code);
        mode_dec_t d;
        d.valid     = (code != 3'd7);
        d.multiword = d.valid && (code >= 3'd3);
        if (code >= 3'd5)      d.level = 2'd2;
        else if (code >= 3'd3) d.level = 2'(code - 3'd3);
        else                   d.level = code[1:0];
        return d;
    endfunction

endpackage

// File: rtl/cycle_resolver.sv
module cycle_resolver
    import dma_strobe_pkg::*;
#(
    parameter int CYC_W = 12
) (
    input  logic [2:0]       mode_code,
    input  logic [CYC_W-1:0] drive_cyc_ns,
    output logic [CYC_W-1:0] req_ns
);
    localparam logic [CYC_W-1:0] SLOW_NS = CYC_W'(CYC_SLOW_NS);
    localparam logic [CYC_W-1:0] FAST_NS = CYC_W'(CYC_FAST_NS);

    mode_dec_t        dec;
    logic [CYC_W-1:0] base_ns;

    always_comb begin
        dec = decode_mode(mode_code);
        if (!dec.valid) begin
            base_ns = '0;
        end else if (dec.multiword && dec.level != 2'd0) begin
            base_ns = (drive_cyc_ns > FAST_NS) ? drive_cyc_ns : FAST_NS;
        end else begin
            base_ns = SLOW_NS;
        end
        req_ns = (base_ns == '0) ? SLOW_NS : base_ns;
    end

    // R4: a request is always usable; R2: never faster than the fast mode cycle
    always_comb begin
        assert_request_valid_R4: assert (req_ns >= FAST_NS);
    end

endmodule

// File: rtl/class_picker.sv
module class_picker
    import dma_strobe_pkg::*;
#(
    parameter int CYC_W = 12
) (
    input  logic [CYC_W-1:0] req_ns,
    output strobe_class_e    cls
);
    always_comb begin
        cls = CLS_A;
        for (int i = NUM_CLS - 1; i >= 0; i--) begin
            if (int'(req_ns) <= cls_cycle_ns(i)) begin
                cls = strobe_class_e'(i[1:0]);
            end
        end
    end

    // R5: the chosen class covers the request unless it is the slowest one
    always_comb begin
        assert_class_covers_R5: assert (cls == CLS_A || int'(req_ns) <= cls_cycle_ns(int'(cls)));
    end

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
    import dma_strobe_pkg::*;
#(
    parameter int CLK_PS = 10000,
    parameter int TICK_W = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  strobe_class_e cls_in,
    output logic          strobe,
    output logic          busy,
    output logic          word_done,
    output strobe_class_e word_class
);
    logic [TICK_W-1:0] act_tab [NUM_CLS];
    logic [TICK_W-1:0] rec_tab [NUM_CLS];

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_ticks
        assign act_tab[g] = TICK_W'(ns_to_ticks(cls_active_ns(g), CLK_PS));
        assign rec_tab[g] = TICK_W'(ns_to_ticks(cls_recov_ns(g), CLK_PS));
    end

    seq_state_e        state_q;
    logic [TICK_W-1:0] cnt_q;
    logic              pend_q;
    logic              done_q;
    strobe_class_e     cls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
            cls_q   <= CLS_A;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_ACTIVE;
                        cls_q   <= cls_in;
                        cnt_q   <= act_tab[cls_in] - TICK_W'(1);
                    end
                end
                ST_ACTIVE: begin
                    if (start) pend_q <= 1'b1;
                    if (cnt_q == '0) begin
                        state_q <= ST_RECOV;
                        cnt_q   <= rec_tab[cls_q] - TICK_W'(1);
                    end else begin
                        cnt_q <= cnt_q - TICK_W'(1);
                    end
                end
                ST_RECOV: begin
                    if (cnt_q == '0) begin
                        done_q <= 1'b1;
                        pend_q <= 1'b0;
                        if (pend_q || start) begin
                            state_q <= ST_ACTIVE;
                            cls_q   <= cls_in;
                            cnt_q   <= act_tab[cls_in] - TICK_W'(1);
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q - TICK_W'(1);
                        if (start) pend_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign strobe     = (state_q == ST_ACTIVE);
    assign busy       = (state_q != ST_IDLE);
    assign word_done  = done_q;
    assign word_class = cls_q;

    // R7: completion is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done);

    // R8: busy only falls when a word completes
    assert_busy_end_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> word_done);

    // R10: class is frozen while the strobe stays high
    assert_class_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> $stable(word_class));

    // R6: the strobe rises only when a word starts or a completion hands over
    assert_strobe_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe) |-> ($past(start) || $past(pend_q) || word_done));

endmodule

// File: rtl/dma_strobe_gen.sv
module dma_strobe_gen
    import dma_strobe_pkg::*;
#(
    parameter int CLK_PS = 10000,
    parameter int CYC_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       mode_code,
    input  logic [CYC_W-1:0] drive_cyc_ns,
    output logic             strobe,
    output logic             busy,
    output logic             word_done,
    output logic [1:0]       word_class
);
    localparam int MAX_TICKS = ns_to_ticks(MAX_PHASE_NS, CLK_PS);
    localparam int TICK_W    = $clog2(MAX_TICKS + 1);

    logic [CYC_W-1:0] req_ns;
    strobe_class_e    cls_sel;
    strobe_class_e    cls_word;

    cycle_resolver #(.CYC_W(CYC_W)) u_resolve (
        .mode_code    (mode_code),
        .drive_cyc_ns (drive_cyc_ns),
        .req_ns       (req_ns)
    );

    class_picker #(.CYC_W(CYC_W)) u_pick (
        .req_ns (req_ns),
        .cls    (cls_sel)
    );

    strobe_seq #(.CLK_PS(CLK_PS), .TICK_W(TICK_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cls_in     (cls_sel),
        .strobe     (strobe),
        .busy       (busy),
        .word_done  (word_done),
        .word_class (cls_word)
    );

    assign word_class = cls_word;

endmodule

// File: tb/dma_strobe_gen_test.sv
module dma_strobe_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode_code = 3'd0;
    logic [11:0] drive_cyc_ns = 12'd0;
    logic        strobe, busy, word_done;
    logic [1:0]  word_class;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_strobe_gen uut (
        .clk(clk), .rst(rst), .start(start), .mode_code(mode_code),
        .drive_cyc_ns(drive_cyc_ns), .strobe(strobe), .busy(busy),
        .word_done(word_done), .word_class(word_class)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected behaviour from the requirements
    function automatic int exp_req(int mode, int drive);
        if (mode == 7) return 480;                              // R4
        if (mode == 4 || mode == 5 || mode == 6)                // R2, R3
            return (drive > 250) ? drive : 250;
        return 480;
    endfunction

    function automatic int exp_cls(int req);                    // R5
        if (req <= 187) return 0;
        if (req <= 250) return 1;
        if (req <= 437) return 2;
        return 3;
    endfunction

    function automatic int ticks(int ns);
        return (ns + 9) / 10;
    endfunction

    function automatic int act_ns(int c);
        case (c) 0: return 62; 1: return 125; 2: return 187; default: return 250; endcase
    endfunction

    function automatic int rec_ns(int c);
        case (c) 0: return 125; 1: return 125; 2: return 250; default: return 312; endcase
    endfunction

    // Count strobe-high and busy-low-strobe cycles from the current negedge until word_done
    task automatic measure(output int hi, output int lo, output bit gap);
        hi = 0; lo = 0; gap = 0;
        forever begin
            if (word_done) break;
            if (strobe) hi++;
            else if (busy) lo++;
            else gap = 1;
            @(negedge clk);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(strobe == 0, "R1 strobe", int'(strobe), 0);
        check(busy == 0, "R1 busy", int'(busy), 0);
        check(word_done == 0, "R1 word_done", int'(word_done), 0);
    endtask

    task automatic t_word(int mode, int drive, string tag);
        int hi, lo, c;
        bit gap;
        mode_code    = 3'(mode);
        drive_cyc_ns = 12'(drive);
        c = exp_cls(exp_req(mode, drive));
        pulse_start();
        measure(hi, lo, gap);
        check(int'(word_class) == c, {tag, " R5 class"}, int'(word_class), c);
        check(hi == ticks(act_ns(c)), {tag, " R6 active ticks"}, hi, ticks(act_ns(c)));
        check(lo == ticks(rec_ns(c)), {tag, " R7 recovery ticks"}, lo, ticks(rec_ns(c)));
        check(!gap, {tag, " R8 busy continuous"}, int'(gap), 0);
        check(busy == 0, {tag, " R8 busy low at done"}, int'(busy), 0);
        @(negedge clk);
        check(word_done == 0, {tag, " R7 done one cycle"}, int'(word_done), 0);
    endtask

    task automatic t_back2back();
        int hi, lo, hi2, lo2;
        bit gap, gap2;
        mode_code    = 3'd4;                 // multiword 1 -> class C, 13/13
        drive_cyc_ns = 12'd0;
        @(negedge clk);
        start = 1'b1;                        // N0
        @(negedge clk);
        start = 1'b0;
        hi = 0; lo = 0; gap = 0;
        for (int n = 1; ; n++) begin         // at negedge n
            if (word_done) break;
            if (strobe) hi++; else if (busy) lo++; else gap = 1;
            if (n == 16 || n == 19) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        check(hi == 13 && lo == 13, "R9 first word timing", hi * 100 + lo, 1313);
        check(!gap, "R9 no idle before handover", int'(gap), 0);
        check(strobe == 1, "R9 next strobe in done cycle", int'(strobe), 1);
        @(negedge clk);
        measure(hi2, lo2, gap2);
        hi2++;
        check(hi2 == 13 && lo2 == 13, "R9 second word timing", hi2 * 100 + lo2, 1313);
        check(busy == 0, "R9 pending merged to one word", int'(busy), 0);
        repeat (3) @(negedge clk);
        check(busy == 0 && strobe == 0, "R9 no third word", int'(busy), 0);
    endtask

    task automatic t_latch();
        int hi, lo;
        bit gap;
        mode_code    = 3'd4;                 // class C
        drive_cyc_ns = 12'd0;
        pulse_start();
        repeat (3) @(negedge clk);
        mode_code = 3'd0;                    // single-word 0 -> class A
        measure(hi, lo, gap);
        hi += 3;
        check(hi == 13, "R10 active unchanged", hi, 13);
        check(lo == 13, "R10 recovery unchanged", lo, 13);
        check(word_class == 2'd1, "R10 class held", int'(word_class), 1);
        t_word(0, 0, "R10 next word");
    endtask

    initial begin
        t_reset();
        t_word(0, 0,   "R2 sw0");
        t_word(2, 100, "R3 sw2 ignores drive");
        t_word(3, 600, "R3 mw0 ignores drive");
        t_word(4, 0,   "R2 mw1");
        t_word(6, 0,   "R2 above mw2 clamp");
        t_word(5, 200, "R3 small drive");
        t_word(5, 300, "R3 drive raise");
        t_word(4, 437, "R5 boundary B");
        t_word(4, 438, "R5 boundary A");
        t_word(6, 900, "R5 above A");
        t_word(7, 0,   "R4 fallback");
        t_back2back();
        t_latch();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog R1-run actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule